// File: doc/BRIEF.md
# Tone Burst Sequencer

This block is the digital sequencing half of a programmable tone generator. It runs on the tone master clock. A modulus phase accumulator turns a 15-bit frequency word into a stream of phase-index steps, 128 per tone cycle. A burst timer counts the programmed duration in tenths of a second. The 7-bit phase index and a square-wave sign bit drive an external sine-weighted converter. The register interface is a set of write strobes: one for frequency, one for duration and one for the mode bits.

A burst begins once a non-zero frequency and a non-zero duration are both held. While a burst plays, new frequency or duration writes are queued as the next burst. The queued burst is taken over at the end of the current one without resetting the phase. A burst may stop only at a permitted point. That point is either the next zero crossing or the end of a whole cycle group, chosen by a mode bit. A second mode bit turns on a repeating pattern of one cycle at f followed by two cycles at 2f.

Top module: `tone_burst_seq`

## Requirements
- R1: After reset, phase_o is 0, active_o is 0, busy_o is 0 and square_o is 0.
- R2: While active, the accumulator adds 128 × frequency word per clock modulo MOD_HZ. Each wrap advances phase_o by 1 (f cycle) or 2 (2f cycle) modulo 128. Between consecutive active samples, phase_o changes by 0, 1 or 2 only.
- R3: A burst starts only when the held frequency and the held duration are both non-zero. A duration written while the frequency is 0 starts nothing, and the burst starts once a non-zero frequency is written.
- R4: A burst stays active for at least duration × TICKS_PER_UNIT clocks. It ends at the first permitted stop point after that.
- R5: With fin_zc_i = 0 the burst ends only after a whole cycle group. The last active phase_o is 127 in an f cycle, or 126 at the end of the second 2f cycle.
- R6: With fin_zc_i = 1 the burst ends at the next zero crossing, which is phase index 0 or 64. The last active phase_o is therefore 63, 62, 127 or 126.
- R7: A frequency or duration written during a burst becomes the next burst. It is taken over at the end of the current one with active_o staying high and no phase discontinuity. If only one of the two was written, the other value is reused.
- R8: A pending value written twice before take-over is replaced: the last write is used.
- R9: Writing a duration of 0 during a burst cancels any pending burst. The current burst then ends at the next permitted stop point, before its timer runs out.
- R10: When a burst ends with nothing pending, the held duration is cleared and the frequency is kept. A later frequency write alone starts nothing, and a later duration write alone restarts with the kept frequency.
- R11: With two_tone_i = 1 the phase steps follow a repeating pattern: one cycle of 128 steps of +1, then two cycles of 64 steps of +2.
- R12: square_o follows the latched square mode bit, and sign_o equals bit 6 of phase_o.
- R13: busy_o is high whenever active_o is high. It is also high while a non-zero duration is held and waiting for a frequency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Tone master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| freq_we_i | input | 1 | Frequency write strobe |
| freq_i | input | 15 | Frequency word |
| dur_we_i | input | 1 | Duration write strobe |
| dur_i | input | 8 | Duration in 0.1 s units |
| mode_we_i | input | 1 | Mode write strobe |
| fin_zc_i | input | 1 | 1: stop at zero crossing, 0: stop after full cycle group |
| two_tone_i | input | 1 | Enable the f / 2f / 2f cycle pattern |
| square_i | input | 1 | Select square wave |
| phase_o | output | 7 | Phase index, 128 steps per cycle |
| sign_o | output | 1 | Square-wave sign bit |
| square_o | output | 1 | Sine (0) or square (1) select |
| active_o | output | 1 | Burst playing |
| busy_o | output | 1 | Burst playing or start armed |

## Verification
The hardest case to reach is the take-over from one burst to the next. It needs a pending value that lands exactly on a permitted stop point after the timer has expired, and it must be shown to cause no phase gap. The bench starts a burst, writes two competing frequencies into the pending slot part-way through, and then observes one unbroken active interval. The count of steps with no phase change over that interval shows which pending frequency was taken over. A zero-crossing end at index 64 needs a duration that expires in the first half of a cycle, so durations and tick counts are chosen to put the expiry there.

// File: rtl/tbs_pkg.sv
package tbs_pkg;
  typedef struct packed {
    logic fin_zc;
    logic two_tone;
    logic square;
  } tone_mode_t;

  localparam int unsigned PH_W = 7;
  localparam logic [1:0] GRP_LAST = 2'd2;
endpackage

// File: rtl/tbs_phase_synth.sv
module tbs_phase_synth #(
  parameter int unsigned FREQ_W = 15,
  parameter int unsigned MOD_HZ = 27_000_000
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    run_i,
  input  logic                    clr_i,
  input  logic                    dbl_i,
  input  logic [FREQ_W-1:0]       freq_i,
  output logic [tbs_pkg::PH_W-1:0] idx_o,
  output logic                    wrap_o,
  output logic                    half_o
);
  localparam int unsigned ACC_W = $clog2(MOD_HZ) + 1;
  localparam int unsigned INC_W = FREQ_W + 7;
  localparam int unsigned SUM_W = ((ACC_W > INC_W) ? ACC_W : INC_W) + 1;

  logic [ACC_W-1:0] acc_q;
  logic [6:0]       idx_q;
  logic [SUM_W-1:0] inc, sum, sum_wr;
  logic [7:0]       nxt;
  logic             step;

  assign inc    = SUM_W'(freq_i) << 7;
  assign sum    = SUM_W'(acc_q) + inc;
  assign sum_wr = sum - SUM_W'(MOD_HZ);
  assign step   = run_i && (sum >= SUM_W'(MOD_HZ));
  assign nxt    = {1'b0, idx_q} + (dbl_i ? 8'd2 : 8'd1);
  assign wrap_o = step && nxt[7];
  assign half_o = step && !nxt[7] && (nxt[6:0] == 7'd64);
  assign idx_o  = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      idx_q <= '0;
    end else if (clr_i) begin
      acc_q <= '0;
      idx_q <= '0;
    end else if (run_i) begin
      if (step) begin
        acc_q <= sum_wr[ACC_W-1:0];
        idx_q <= nxt[6:0];
      end else begin
        acc_q <= sum[ACC_W-1:0];
      end
    end
  end

  AST_ACC_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_q < ACC_W'(MOD_HZ)); // R2
  AST_IDX_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !clr_i) |=> $stable(idx_q)); // R2
endmodule

// File: rtl/tbs_burst_timer.sv
module tbs_burst_timer #(
  parameter int unsigned DUR_W          = 8,
  parameter int unsigned TICKS_PER_UNIT = 2_700_000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [DUR_W-1:0] dur_i,
  input  logic             run_i,
  output logic             expired_o
);
  localparam int unsigned TICK_W = $clog2(TICKS_PER_UNIT + 1);

  logic [TICK_W-1:0] tick_q;
  logic [DUR_W-1:0]  rem_q;

  assign expired_o = (rem_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q <= '0;
      rem_q  <= '0;
    end else if (load_i) begin
      tick_q <= '0;
      rem_q  <= dur_i;
    end else if (run_i && !expired_o) begin
      if (tick_q == TICK_W'(TICKS_PER_UNIT - 1)) begin
        tick_q <= '0;
        rem_q  <= rem_q - 1'b1;
      end else begin
        tick_q <= tick_q + 1'b1;
      end
    end
  end

  AST_TICK_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_q < TICK_W'(TICKS_PER_UNIT)); // R4
  AST_EXPIRE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expired_o && !load_i) |=> expired_o); // R4
endmodule

// File: rtl/tbs_sched.sv
module tbs_sched #(
  parameter int unsigned FREQ_W = 15,
  parameter int unsigned DUR_W  = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                freq_we_i,
  input  logic [FREQ_W-1:0]   freq_i,
  input  logic                dur_we_i,
  input  logic [DUR_W-1:0]    dur_i,
  input  logic                mode_we_i,
  input  tbs_pkg::tone_mode_t mode_i,
  input  logic                wrap_i,
  input  logic                half_i,
  input  logic                expired_i,
  output logic                run_o,
  output logic                clr_o,
  output logic                load_o,
  output logic [DUR_W-1:0]    load_dur_o,
  output logic [FREQ_W-1:0]   freq_o,
  output logic                dbl_o,
  output logic                square_o,
  output logic                active_o,
  output logic                busy_o
);
  import tbs_pkg::*;

  tone_mode_t        mode_q;
  logic              active_q, stop_q, pf_v, pd_v;
  logic [FREQ_W-1:0] freq_q, pf_q, nxt_freq;
  logic [DUR_W-1:0]  dur_q, pd_q, nxt_dur;
  logic [1:0]        grp_q;
  logic              start, full_pt, stop_pt, fin, handover, finish, idle_wr;

  assign start    = !active_q && (dur_q != '0) && (freq_q != '0) && !freq_we_i && !dur_we_i;
  assign full_pt  = wrap_i && (!mode_q.two_tone || grp_q == GRP_LAST);
  assign stop_pt  = mode_q.fin_zc ? (wrap_i || half_i) : full_pt;
  assign fin      = active_q && stop_pt && (stop_q || expired_i);
  assign nxt_freq = pf_v ? pf_q : freq_q;
  assign nxt_dur  = pd_v ? pd_q : dur_q;
  assign handover = fin && !stop_q && (pf_v || pd_v) && (nxt_freq != '0) && (nxt_dur != '0);
  assign finish   = fin && !handover;
  assign idle_wr  = !active_q || finish;

  assign run_o      = active_q;
  assign clr_o      = start || finish;
  assign load_o     = start || handover;
  assign load_dur_o = start ? dur_q : nxt_dur;
  assign freq_o     = freq_q;
  assign dbl_o      = mode_q.two_tone && (grp_q != 2'd0);
  assign square_o   = mode_q.square;
  assign active_o   = active_q;
  assign busy_o     = active_q || (dur_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
    end else if (mode_we_i) begin
      mode_q <= mode_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      stop_q   <= 1'b0;
      pf_v     <= 1'b0;
      pd_v     <= 1'b0;
      freq_q   <= '0;
      pf_q     <= '0;
      dur_q    <= '0;
      pd_q     <= '0;
      grp_q    <= '0;
    end else begin
      if (start) begin
        active_q <= 1'b1;
        grp_q    <= '0;
        stop_q   <= 1'b0;
        pf_v     <= 1'b0;
        pd_v     <= 1'b0;
      end else if (finish) begin
        active_q <= 1'b0;
        dur_q    <= '0;
        if (pf_v && !stop_q) freq_q <= pf_q;
        grp_q    <= '0;
        stop_q   <= 1'b0;
        pf_v     <= 1'b0;
        pd_v     <= 1'b0;
      end else begin
        if (handover) begin
          freq_q <= nxt_freq;
          dur_q  <= nxt_dur;
          pf_v   <= 1'b0;
          pd_v   <= 1'b0;
        end
        if (active_q && wrap_i) begin
          if (!mode_q.two_tone || grp_q == GRP_LAST) grp_q <= '0;
          else                                       grp_q <= grp_q + 1'b1;
        end
      end
      // writes land after take-over so a late write queues for the following burst
      if (freq_we_i) begin
        if (idle_wr) freq_q <= freq_i;
        else begin
          pf_q <= freq_i;
          pf_v <= 1'b1;
        end
      end
      if (dur_we_i) begin
        if (idle_wr) dur_q <= dur_i;
        else if (dur_i == '0) begin
          stop_q <= 1'b1;
          pf_v   <= 1'b0;
          pd_v   <= 1'b0;
        end else begin
          pd_q   <= dur_i;
          pd_v   <= 1'b1;
          stop_q <= 1'b0;
        end
      end
    end
  end

  AST_START_NEEDS_BOTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_q) |-> ($past(freq_q) != '0 && $past(dur_q) != '0)); // R3
  AST_END_AT_STOP_POINT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active_q) |-> $past(wrap_i || half_i)); // R6
  AST_FULL_CYCLE_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(active_q) && !$past(mode_q.fin_zc)) |-> $past(wrap_i)); // R5
  AST_DUR_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(active_q) && !$past(dur_we_i)) |-> (dur_q == '0)); // R10
  AST_GRP_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grp_q <= GRP_LAST); // R11
endmodule

// File: rtl/tone_burst_seq.sv
module tone_burst_seq #(
  parameter int unsigned FREQ_W         = 15,
  parameter int unsigned DUR_W          = 8,
  parameter int unsigned MOD_HZ         = 27_000_000,
  parameter int unsigned TICKS_PER_UNIT = 2_700_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              freq_we_i,
  input  logic [FREQ_W-1:0] freq_i,
  input  logic              dur_we_i,
  input  logic [DUR_W-1:0]  dur_i,
  input  logic              mode_we_i,
  input  logic              fin_zc_i,
  input  logic              two_tone_i,
  input  logic              square_i,
  output logic [6:0]        phase_o,
  output logic              sign_o,
  output logic              square_o,
  output logic              active_o,
  output logic              busy_o
);
  import tbs_pkg::*;

  tone_mode_t        mode_in;
  logic              run, clr, load, dbl, wrap, half, expired;
  logic [DUR_W-1:0]  load_dur;
  logic [FREQ_W-1:0] cur_freq;

  assign mode_in = '{fin_zc: fin_zc_i, two_tone: two_tone_i, square: square_i};

  tbs_sched #(.FREQ_W(FREQ_W), .DUR_W(DUR_W)) i_sched (
    .clk_i, .rst_ni, .freq_we_i, .freq_i, .dur_we_i, .dur_i, .mode_we_i,
    .mode_i(mode_in), .wrap_i(wrap), .half_i(half), .expired_i(expired),
    .run_o(run), .clr_o(clr), .load_o(load), .load_dur_o(load_dur),
    .freq_o(cur_freq), .dbl_o(dbl), .square_o, .active_o, .busy_o
  );

  tbs_phase_synth #(.FREQ_W(FREQ_W), .MOD_HZ(MOD_HZ)) i_phase (
    .clk_i, .rst_ni, .run_i(run), .clr_i(clr), .dbl_i(dbl), .freq_i(cur_freq),
    .idx_o(phase_o), .wrap_o(wrap), .half_o(half)
  );

  tbs_burst_timer #(.DUR_W(DUR_W), .TICKS_PER_UNIT(TICKS_PER_UNIT)) i_timer (
    .clk_i, .rst_ni, .load_i(load), .dur_i(load_dur), .run_i(run),
    .expired_o(expired)
  );

  assign sign_o = phase_o[6];

  AST_IDLE_PHASE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_o |-> (phase_o == 7'd0)); // R1
  AST_BUSY_WHILE_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_o) |-> busy_o); // R13
endmodule

// File: tb/test_tone_burst_seq.sv
module test_tone_burst_seq;
  localparam int unsigned MODV  = 2560;
  localparam int unsigned TICKS = 200;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic freq_we_i = 1'b0, dur_we_i = 1'b0, mode_we_i = 1'b0;
  logic [14:0] freq_i = '0;
  logic [7:0]  dur_i = '0;
  logic fin_zc_i = 1'b0, two_tone_i = 1'b0, square_i = 1'b0;
  logic [6:0] phase_o;
  logic sign_o, square_o, active_o, busy_o;

  tone_burst_seq #(.MOD_HZ(MODV), .TICKS_PER_UNIT(TICKS)) i_tone_burst_seq (.*);

  always #10 clk_i = ~clk_i;

  int checks = 0, errors = 0;
  int act_len, zeros, n1, n2, bad, falls, busy_bad, sign_bad, last_ph;
  logic prev_act = 1'b0;
  logic [6:0] prev_ph = '0;
  logic mon_en = 1'b0;

  always @(negedge clk_i) if (mon_en) begin
    if (active_o) begin
      act_len++;
      if (prev_act) begin
        case (7'(phase_o - prev_ph))
          7'd0: zeros++;
          7'd1: n1++;
          7'd2: n2++;
          default: bad++;
        endcase
      end
      last_ph = phase_o;
      if (!busy_o) busy_bad++;
      if (sign_o != phase_o[6]) sign_bad++;
    end
    if (prev_act && !active_o) falls++;
    prev_act = active_o;
    prev_ph  = phase_o;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clr_stats();
    act_len = 0; zeros = 0; n1 = 0; n2 = 0; bad = 0; falls = 0;
    busy_bad = 0; sign_bad = 0; last_ph = -1;
  endtask

  task automatic wr_freq(input int v);
    @(negedge clk_i); freq_we_i = 1'b1; freq_i = 15'(v);
    @(negedge clk_i); freq_we_i = 1'b0;
  endtask

  task automatic wr_dur(input int v);
    @(negedge clk_i); dur_we_i = 1'b1; dur_i = 8'(v);
    @(negedge clk_i); dur_we_i = 1'b0;
  endtask

  task automatic wr_mode(input bit zc, input bit two, input bit sq);
    @(negedge clk_i); mode_we_i = 1'b1; fin_zc_i = zc; two_tone_i = two; square_i = sq;
    @(negedge clk_i); mode_we_i = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic wait_end(input string tag);
    int n = 0;
    while (!active_o && n < 20) begin @(negedge clk_i); n++; end
    chk(active_o, {tag, " start"}, active_o, 1);
    n = 0;
    while (active_o && n < 6000) begin @(negedge clk_i); n++; end
    chk(!active_o, {tag, " end"}, active_o, 0);
    idle(2);
  endtask

  task automatic t_reset();
    chk(phase_o == 0, "R1 phase", phase_o, 0);
    chk(!active_o, "R1 active", active_o, 0);
    chk(!busy_o, "R1 busy", busy_o, 0);
    chk(!square_o, "R1 square", square_o, 0);
  endtask

  task automatic t_need_freq();
    clr_stats();
    wr_dur(2);
    idle(20);
    chk(!active_o, "R3 no start without freq", active_o, 0);
    chk(busy_o, "R13 busy with armed duration", busy_o, 1);
    wr_freq(10);
    wait_end("R3");
    chk(act_len >= 400 && act_len <= 660, "R4 burst length", act_len, 512);
    chk(last_ph == 127, "R5 full cycle end", last_ph, 127);
    chk(bad == 0, "R2 phase steps", bad, 0);
    chk(busy_bad == 0, "R13 busy while active", busy_bad, 0);
  endtask

  task automatic t_retain();
    wr_freq(10);
    idle(30);
    chk(!active_o, "R10 duration cleared", active_o, 0);
    clr_stats();
    wr_dur(1);
    wait_end("R10");
    chk(act_len >= 252 && act_len <= 260, "R10 kept frequency", act_len, 256);
  endtask

  task automatic t_zc();
    wr_mode(1'b1, 1'b0, 1'b0);
    clr_stats();
    wr_dur(3);
    wait_end("R6");
    chk(last_ph == 63, "R6 zero crossing end", last_ph, 63);
    chk(act_len >= 600 && act_len <= 644, "R6 length", act_len, 640);
  endtask

  task automatic t_two();
    wr_mode(1'b0, 1'b1, 1'b1);
    wr_freq(20);
    clr_stats();
    wr_dur(3);
    chk(square_o, "R12 square select", square_o, 1);
    wait_end("R11");
    chk(n1 > 0 && n1 % 128 == 0, "R11 f cycles", n1, 384);
    chk(n2 == n1 - 1, "R11 2f cycles", n2, n1 - 1);
    chk(last_ph == 126, "R5 end after 2f pair", last_ph, 126);
    chk(sign_bad == 0, "R12 sign bit", sign_bad, 0);
  endtask

  task automatic t_handover();
    wr_mode(1'b0, 1'b0, 1'b0);
    chk(!square_o, "R12 sine select", square_o, 0);
    wr_freq(10);
    clr_stats();
    wr_dur(1);
    idle(50);
    wr_freq(5);
    wr_freq(20);
    wait_end("R7");
    chk(falls == 1, "R7 no gap at take-over", falls, 1);
    chk(act_len >= 508 && act_len <= 516, "R7 two bursts length", act_len, 512);
    chk(bad == 0, "R7 phase continuous", bad, 0);
    chk(zeros >= 124 && zeros <= 132, "R8 last pending freq used", zeros, 128);
  endtask

  task automatic t_stop();
    wr_freq(10);
    clr_stats();
    wr_dur(10);
    idle(300);
    wr_dur(0);
    wait_end("R9");
    chk(act_len >= 300 && act_len <= 520, "R9 early stop", act_len, 512);
    chk(last_ph == 127, "R9 stop point", last_ph, 127);
  endtask

  initial begin
    #(20 * 200000);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    clr_stats();
    idle(3);
    t_reset();
    rst_ni = 1'b1;
    idle(2);
    t_reset();
    mon_en = 1'b1;
    t_need_freq();
    t_retain();
    t_zc();
    t_two();
    t_handover();
    t_stop();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule